// File: doc/BRIEF.md
# I2C Target Receive Engine with Clock Stretching

This block is the receive side of an I2C target. It watches the two bus lines, finds START, repeated START and STOP, and shifts in the 7-bit address with its direction bit. The address is compared against a programmed address. When general-call response is enabled, the all-zero write address is also accepted. On a matching write address the block acknowledges the address, raises an event flag and then holds SCL low. The master waits until software has cleared that flag. After that the block takes in data bytes one at a time. Each byte is acknowledged or refused depending on a software control bit, and SCL is stretched again after every acknowledged byte until software has dealt with the byte.

Received bytes leave through a one-entry valid/ready stream. `rx_valid` is the receive-buffer-full flag, and `rx_data` holds the byte. A transfer happens on any clock edge where both `rx_valid` and `rx_ready` are high, and that transfer empties the buffer. While the buffer stays untaken, the block stretches SCL, so the master is throttled. `rx_data` stays stable until it is taken. The one exception is when software releases the bus by clearing the byte-end flag without taking the byte: the next byte then replaces the old one. The line drivers are modeled as active-high pull-low requests, and the bus itself is open-drain.

The event flags are set by the engine and cleared by software writing ones. A masked OR of the flags forms one interrupt line.

Top module: `i2c_stretch_rx`

## Requirements
- R1: An SDA fall while SCL is high starts address reception. An SDA rise while SCL is high is a STOP: it releases both lines and sets the stop flag (bit 1) only if a START flag was raised since the last START. After reset all flags, pulls, `rx_valid` and `irq` are 0.
- R2: The address byte arrives MSB first, 7 address bits followed by the direction bit (0 = master writes). A write to `own_addr` is answered with ACK (SDA pulled low) during the 9th SCL pulse. It also sets the START flag (bit 0) and sets `xfer_dir` to 0.
- R3: For any other address the block neither acknowledges nor sets a flag, and it ignores the bus until the next START.
- R4: The write address 0000000 is treated as a match only while `gc_en` is 1. After such a match, data bytes are received and acknowledged.
- R5: A matching address with direction bit 1 sets `xfer_dir` to 1 and is not acknowledged. No START flag is set and the bus is left free.
- R6: After the address ACK, SCL is held low from the 9th falling edge until the START flag is 0.
- R7: After 8 data bits, the byte appears on `rx_data` with `rx_valid` (bit 3) and the byte-end flag (bit 2) set, and it is acknowledged in the 9th pulse. If `nack_last` is 1 at that point, the byte is refused with NACK instead.
- R8: After an acknowledged byte, SCL is held low from the 9th falling edge until the byte is taken through the stream or bit 2 or bit 3 is cleared. Clearing bit 2 alone leaves `rx_valid` set.
- R9: After a refused byte, SCL and SDA are released and later bytes before the next START are ignored.
- R10: Writing 1 to a bit of `flag_clr` clears that flag. Writing 0 has no effect. A set in the same cycle wins.
- R11: `irq` is high exactly when a flag is set whose bit in `irq_en` is 1.
- R12: A repeated START without STOP restarts address checking, and a match sets the START flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 = pull SCL low (stretch) |
| sda_pull | output | 1 | 1 = pull SDA low (ACK) |
| own_addr | input | ADDR_W | Programmed target address |
| gc_en | input | 1 | Respond to the general-call address |
| nack_last | input | 1 | Refuse the byte completing now |
| rx_data | output | ADDR_W+1 | Received byte |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer takes the byte |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| flags | output | 4 | bit0 START, bit1 STOP, bit2 byte-end, bit3 buffer full |
| xfer_dir | output | 1 | Direction bit of the last matched address |
| irq_en | input | 4 | Per-flag interrupt enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that SDA changes only while SCL is low, except for deliberate START and STOP. They also assume that each SCL phase lasts longer than the synchronizer delay, so every edge is seen as a single event. The bench master follows both rules. It changes SDA a quarter bit after pulling SCL low, and it uses multi-cycle high and low phases. Before raising SCL it waits until the wired-AND bus actually goes high, so every stretch is honored. Software-side clears and stream reads are driven between clock edges as single-cycle pulses.

// File: rtl/i2c_srx_pkg.sv
`timescale 1ns/1ps
package i2c_srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_AHOLD,
    ST_DATA,
    ST_DACK,
    ST_DHOLD
  } rx_state_t;

  localparam int FLAG_W   = 4;
  localparam int FL_START = 0;
  localparam int FL_STOP  = 1;
  localparam int FL_BEND  = 2;
  localparam int FL_RBF   = 3;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       byte_done;
    logic [7:0] data;
  } rx_evt_t;

endpackage

// File: rtl/i2c_srx_sync.sv
`timescale 1ns/1ps
module i2c_srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  // line conditions: SDA moves while SCL stays high
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_srx_fsm.sv
`timescale 1ns/1ps
module i2c_srx_fsm
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              nack_last,
  input  logic              start_pending,
  input  logic              byte_pending,
  output logic              scl_low,
  output logic              sda_low,
  output logic              dir,
  output rx_evt_t           evt
);

  localparam int FRAME_W = ADDR_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  rx_state_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic               engaged, nacked;
  logic [ADDR_W-1:0]  addr_rx;
  logic               rw_rx, own_hit, gc_hit, hit, frame_end;

  assign addr_rx   = sh[FRAME_W-1:1];
  assign rw_rx     = sh[0];
  assign own_hit   = (addr_rx == own_addr);
  assign gc_hit    = gc_en && (addr_rx == '0) && !rw_rx;
  assign hit       = own_hit || gc_hit;
  assign frame_end = scl_fall && (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      dir     <= 1'b0;
      engaged <= 1'b0;
      nacked  <= 1'b0;
      evt     <= '0;
    end else begin
      evt.start     <= 1'b0;
      evt.stop      <= 1'b0;
      evt.byte_done <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        scl_low <= 1'b0;
        sda_low <= 1'b0;
        engaged <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        scl_low  <= 1'b0;
        sda_low  <= 1'b0;
        evt.stop <= engaged;
        engaged  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              sh  <= {sh[FRAME_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (frame_end && state == ST_ADDR) begin
              state <= ST_IDLE;
              if (hit) begin
                dir <= rw_rx;
                if (!rw_rx) begin
                  sda_low   <= 1'b1;
                  evt.start <= 1'b1;
                  engaged   <= 1'b1;
                  state     <= ST_AACK;
                end
              end
            end else if (frame_end) begin
              evt.byte_done <= 1'b1;
              evt.data      <= sh;
              sda_low       <= !nack_last;
              nacked        <= nack_last;
              state         <= ST_DACK;
            end
          end
          ST_AACK: if (scl_fall) begin
            sda_low <= 1'b0;
            scl_low <= start_pending;
            state   <= ST_AHOLD;
          end
          ST_AHOLD: if (!start_pending) begin
            scl_low <= 1'b0;
            cnt     <= '0;
            state   <= ST_DATA;
          end
          ST_DACK: if (scl_fall) begin
            sda_low <= 1'b0;
            if (nacked) state <= ST_IDLE;
            else begin
              scl_low <= byte_pending;
              state   <= ST_DHOLD;
            end
          end
          ST_DHOLD: if (!byte_pending) begin
            scl_low <= 1'b0;
            cnt     <= '0;
            state   <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> (state == ST_AACK || state == ST_DACK));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AHOLD && start_pending && $stable(state)) |-> scl_low);

  p_idle_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!scl_low && !sda_low));

endmodule

// File: rtl/i2c_stretch_rx.sv
`timescale 1ns/1ps
module i2c_stretch_rx
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              nack_last,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [3:0]        flag_clr,
  output logic [3:0]        flags,
  output logic              xfer_dir,
  input  logic [3:0]        irq_en,
  output logic              irq
);

  logic    sda_s, scl_rise, scl_fall, start_det, stop_det;
  rx_evt_t evt;
  logic [FLAG_W-1:0] set_v, clr_v;
  logic [ADDR_W:0]   rx_buf;
  logic              rx_fire;

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_srx_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .gc_en(gc_en), .nack_last(nack_last),
    .start_pending(flags[FL_START]),
    .byte_pending(flags[FL_RBF] & flags[FL_BEND]),
    .scl_low(scl_pull), .sda_low(sda_pull), .dir(xfer_dir), .evt(evt)
  );

  assign rx_fire = rx_valid && rx_ready;

  always_comb begin
    set_v           = '0;
    set_v[FL_START] = evt.start;
    set_v[FL_STOP]  = evt.stop;
    set_v[FL_BEND]  = evt.byte_done;
    set_v[FL_RBF]   = evt.byte_done;
    clr_v           = flag_clr;
    clr_v[FL_RBF]   = flag_clr[FL_RBF] | rx_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      rx_buf <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (evt.byte_done) rx_buf <= evt.data[ADDR_W:0];
    end
  end

  assign rx_valid = flags[FL_RBF];
  assign rx_data  = rx_buf;
  assign irq      = |(flags & irq_en);

  p_pair_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> flags[FL_BEND]);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[FL_STOP] && !evt.stop) |=> !flags[FL_STOP]);

  p_rx_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !evt.byte_done) |=> $stable(rx_data));

endmodule

// File: tb/i2c_stretch_rx_bench.sv
`timescale 1ns/1ps
module i2c_stretch_rx_bench;

  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull, scl_bus, sda_bus;
  logic gc_en = 1'b0, nack_last = 1'b0, rx_ready = 1'b0;
  logic [3:0] flag_clr = '0, irq_en = '0, flags;
  logic [7:0] rx_data;
  logic rx_valid, xfer_dir, irq;
  logic ack;
  bit   auto_read = 1'b0;
  int   checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  assign scl_bus = scl_m & ~scl_pull;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_stretch_rx u_i2c_stretch_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(MY_ADDR),
    .gc_en(gc_en), .nack_last(nack_last), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .flag_clr(flag_clr),
    .flags(flags), .xfer_dir(xfer_dir), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(H);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic got_ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(H/2);
    got_ack = !sda_bus; cyc(H/2);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_start();
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(H);
    sda_m = 1'b0; cyc(H);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(H);
    sda_m = 1'b1; cyc(H);
  endtask

  task automatic sw_clear(input logic [3:0] v);
    @(negedge clk) flag_clr = v;
    @(negedge clk) flag_clr = '0;
  endtask

  // driver side: push what the design must deliver, then clock it in
  task automatic send_data(input logic [7:0] b);
    exp_q.push_back(b);
    m_byte(b, ack);
  endtask

  // monitor: takes bytes from the stream and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (auto_read && rx_valid && !rx_ready) begin
        if (exp_q.size() == 0) check("R7 unexpected byte", rx_data, 32'hFFFF);
        else check("R7 byte value", rx_data, exp_q.pop_front());
        rx_ready = 1'b1;
      end else rx_ready = 1'b0;
    end
  end

  initial begin
    cyc(150000);
    check("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(5); rst_n = 1'b1; cyc(5);
    check("R1 reset flags", flags, 0);
    check("R1 reset pulls", {scl_pull, sda_pull}, 0);
    check("R1 reset rx_valid/irq", {rx_valid, irq}, 0);

    // R2 / R6: matching write address
    m_start();
    m_byte({MY_ADDR, 1'b0}, ack);
    check("R2 address ack", ack, 1);
    check("R2 start flag", flags[0], 1);
    check("R2 direction write", xfer_dir, 0);
    check("R6 scl held", scl_pull, 1);
    cyc(50);
    check("R6 scl still held", scl_pull, 1);
    sw_clear(4'b0001); cyc(3);
    check("R6 scl released", scl_pull, 0);

    // R7: stream of bytes through the scoreboard
    auto_read = 1'b1;
    send_data(8'hA5); check("R7 ack A5", ack, 1);
    send_data(8'h3C); check("R7 ack 3C", ack, 1);
    send_data(8'h00); check("R7 ack 00", ack, 1);
    cyc(5);
    check("R7 queue drained", exp_q.size(), 0);

    // R8: hold until byte-end cleared, byte kept
    auto_read = 1'b0;
    send_data(8'hC7);
    check("R8 ack", ack, 1);
    check("R8 scl held", scl_pull, 1);
    check("R8 flags set", flags[3:2], 2'b11);
    cyc(30);
    check("R8 scl still held", scl_pull, 1);
    sw_clear(4'b0100); cyc(3);
    check("R8 released by byte-end clear", scl_pull, 0);
    check("R8 byte kept", rx_valid, 1);
    auto_read = 1'b1; cyc(5);
    check("R8 stream take empties", rx_valid, 0);

    // R7 / R9: refused last byte
    nack_last = 1'b1;
    send_data(8'h81);
    nack_last = 1'b0;
    check("R7 nack", ack, 0);
    check("R9 no hold", scl_pull, 0);
    cyc(5); sw_clear(4'b0100);
    m_byte(8'h55, ack);
    check("R9 later byte not acked", ack, 0);
    check("R9 later byte ignored", {rx_valid, flags[2]}, 0);
    m_stop(); cyc(5);
    check("R1 stop flag", flags[1], 1);
    sw_clear(4'b1111);

    // R3: other address
    m_start();
    m_byte({7'h11, 1'b0}, ack);
    check("R3 no ack", ack, 0);
    check("R3 no flags", flags, 0);
    m_byte(8'h99, ack);
    check("R3 data ignored", {ack, rx_valid, scl_pull}, 0);
    m_stop(); cyc(5);
    check("R3 no stop flag", flags[1], 0);

    // R4: general call
    m_start();
    m_byte(8'h00, ack);
    check("R4 gc disabled no ack", {ack, flags[0]}, 0);
    m_stop();
    gc_en = 1'b1;
    m_start();
    m_byte(8'h00, ack);
    check("R4 gc ack", ack, 1);
    check("R4 gc start flag", flags[0], 1);
    sw_clear(4'b0001);
    send_data(8'h6E);
    check("R4 gc data acked", ack, 1);
    m_stop(); cyc(5);
    gc_en = 1'b0;
    sw_clear(4'b1111);

    // R5: read request
    m_start();
    m_byte({MY_ADDR, 1'b1}, ack);
    check("R5 read not acked", ack, 0);
    check("R5 direction read", xfer_dir, 1);
    check("R5 no start flag, bus free", {flags[0], scl_pull}, 0);
    m_stop();

    // R12: repeated start
    m_start();
    m_byte({MY_ADDR, 1'b0}, ack);
    sw_clear(4'b0001);
    send_data(8'h12);
    m_start();
    check("R12 no flag before address", flags[0], 0);
    m_byte({MY_ADDR, 1'b0}, ack);
    check("R12 ack again", ack, 1);
    check("R12 start flag again", flags[0], 1);
    sw_clear(4'b0001);
    m_stop(); cyc(5);

    // R10: write-1 clear
    check("R10 pre state", flags[2:1], 2'b11);
    sw_clear(4'b0000); cyc(2);
    check("R10 zero write no effect", flags[2:1], 2'b11);
    sw_clear(4'b0010); cyc(2);
    check("R10 one write clears", flags[2:1], 2'b10);

    // R11: interrupt mask
    irq_en = 4'b0100; cyc(2);
    check("R11 enabled flag raises irq", irq, 1);
    irq_en = 4'b0001; cyc(2);
    check("R11 disabled flag quiet", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule